// File: doc/BRIEF.md
# Parallel-In Serial-Out FIFO

This block is a single-clock FIFO. It takes whole 16-bit words on a parallel write port and hands them back one bit per shift strobe on a single serial output line. Storage is a 1024-entry array that is addressed by two circular pointers. A word stays in the FIFO until its last bit has been shifted out. Only then does the read pointer move and the occupancy drop.

Four active-low flags report the fill level. They show empty, full, more than half full, and a two-sided flag for "nearly empty or nearly full". The shift order inside each word is either least-significant bit first or most-significant bit first. A direction input picks the order, and the block captures it once after every reset. The design targets a producer that writes words at bus speed and a consumer that clocks out a serial stream, for example a printer head or a line driver.

Top module: `psf_fifo`

## Requirements
- R1: While `rst` is high on a clock edge, the occupancy and both pointers clear. After that edge `empty_n`=0, `almost_n`=0, `full_n`=1, `half_n`=1 and `so`=0.
- R2: Words come out in the order in which they were accepted. Each accepted write stores `wr_data` at the write pointer and advances that pointer.
- R3: A write is dropped without changing any state when the FIFO holds 1024 words. A write is also dropped on any edge where `rst` is high.
- R4: An `sh_en` edge with at least one word stored advances the bit position by one. The 16th shift of a word retires that word. `sh_en` is ignored while the FIFO is empty, and `so` is held at 0 while the FIFO is empty.
- R5: `dir_msb` is captured on the first clock edge after reset is released. A value of 0 selects bit 0 first, then bit 1 up to bit 15. A value of 1 selects bit 15 first, then down to bit 0. Later changes of `dir_msb` have no effect until the next reset.
- R6: `empty_n` is 0 exactly when no word that has not been fully shifted is stored.
- R7: `full_n` is 0 exactly when 1024 words are stored.
- R8: `half_n` is 0 exactly when more than 512 words are stored.
- R9: `almost_n` is 0 when fewer than 128 words or more than 896 words are stored. It is 1 from 128 to 896 words inclusive.
- R10: A write that is accepted on the same edge as a word is retired leaves the occupancy unchanged. When the FIFO is full, the write on that edge is dropped and the read still proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for the word on `wr_data` |
| wr_data | input | 16 | Parallel write data |
| sh_en | input | 1 | Serial shift request, one bit per edge |
| dir_msb | input | 1 | Shift order select, captured after reset (1 = MSB first) |
| so | output | 1 | Serial data, the current bit of the head word |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when all 1024 entries are in use |
| half_n | output | 1 | Low when more than 512 words are stored |
| almost_n | output | 1 | Low below 128 or above 896 stored words |

## Verification
The first pattern writes a few words and shifts them out continuously, then keeps shifting past the end. It shows whether the bit order, the word boundary and the empty guard are correct in LSB-first mode. The second pattern is a long burst of writes to capacity followed by extra writes. It walks the occupancy through every flag threshold and tells a dropped write apart from a stored one, because each dropped word must be missing from the later drain. Next comes a phase that writes and shifts at once, both at full and at random mid-levels, followed by a complete drain. This phase separates a correct simultaneous push and pop from one that loses or double-counts a word. The last pattern resets with MSB-first selected, then toggles the direction input while words are in flight, to show that the order is fixed at capture time.

// File: rtl/psf_pkg.sv
package psf_pkg;

    typedef enum logic {
        ORDER_LSB = 1'b0,
        ORDER_MSB = 1'b1
    } order_e;

    typedef struct packed {
        logic push;
        logic pop;
    } occ_evt_t;

    // index of the bit sent at position pos within a word of width w
    function automatic int pick_index(int pos, int w, order_e ord);
        if (ord == ORDER_MSB) begin
            return w - 1 - pos;
        end
        return pos;
    endfunction

endpackage

// File: rtl/psf_store.sv
module psf_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/psf_ptrs.sv
module psf_ptrs
    import psf_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          pop_req,
    output logic          wr_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          have_word
);

    localparam logic [CW-1:0] CAP     = CW'(DEPTH);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

    occ_evt_t evt;

    assign have_word = (count != '0);
    assign wr_ok     = wr_req && !rst && (count != CAP);
    assign evt.push  = wr_ok;
    assign evt.pop   = pop_req && have_word && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (evt.push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (evt.pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case (evt)
                occ_evt_t'{push: 1'b1, pop: 1'b0}: count <= count + 1'b1;
                occ_evt_t'{push: 1'b0, pop: 1'b1}: count <= count - 1'b1;
                default:                           count <= count;
            endcase
        end
    end

endmodule

// File: rtl/psf_shifter.sv
module psf_shifter
    import psf_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int IW    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sh_en,
    input  logic              have_word,
    input  logic              dir_in,
    input  logic [WORD_W-1:0] word,
    output logic              so,
    output logic              word_done
);

    localparam logic [IW-1:0] LAST_POS = IW'(WORD_W - 1);

    logic [IW-1:0] pos;
    logic [IW-1:0] idx;
    logic          locked;
    order_e        ord_q;
    logic          step;

    assign step      = sh_en && have_word && !rst;
    assign word_done = step && (pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            ord_q  <= ORDER_LSB;
        end else if (!locked) begin
            locked <= 1'b1;
            ord_q  <= dir_in ? ORDER_MSB : ORDER_LSB;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        end
    end

    always_comb begin
        idx = IW'(pick_index(int'(pos), WORD_W, ord_q));
        so  = have_word ? word[idx] : 1'b0;
    end

endmodule

// File: rtl/psf_flags.sv
module psf_flags #(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n,
    output logic          almost_n
);

    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LOW  = CW'(DEPTH / 8);
    localparam logic [CW-1:0] HIGH = CW'(DEPTH - DEPTH / 8);

    always_comb begin
        empty_n  = (count != '0);
        full_n   = (count != CAP);
        half_n   = !(count > HALF);
        almost_n = (count >= LOW) && (count <= HIGH);
    end

endmodule

// File: rtl/psf_fifo.sv
module psf_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sh_en,
    input  logic              dir_msb,
    output logic              so,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n,
    output logic              almost_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic              wr_ok;
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              have_word;
    logic              word_done;
    logic [WORD_W-1:0] head;

    psf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_en),
        .pop_req   (word_done),
        .wr_ok     (wr_ok),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .have_word (have_word)
    );

    psf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_addr (wr_ptr),
        .wr_data (wr_data),
        .rd_addr (rd_ptr),
        .rd_data (head)
    );

    psf_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sh_en     (sh_en),
        .have_word (have_word),
        .dir_in    (dir_msb),
        .word      (head),
        .so        (so),
        .word_done (word_done)
    );

    psf_flags #(.DEPTH(DEPTH)) u_flags (
        .count    (count),
        .empty_n  (empty_n),
        .full_n   (full_n),
        .half_n   (half_n),
        .almost_n (almost_n)
    );

endmodule

// File: rtl/psf_fifo_chk.sv
module psf_fifo_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic sh_en,
    input logic so,
    input logic empty_n,
    input logic full_n,
    input logic half_n,
    input logic almost_n
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!empty_n && full_n && half_n && !almost_n && !so)); // R1

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_en && !sh_en) |=> !full_n); // R3

    AST_EMPTY_SHIFT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && sh_en && !wr_en) |=> !empty_n); // R4

    AST_SO_QUIET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !so); // R4

    AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(!full_n && !empty_n)); // R6 R7

    AST_FULL_LEVELS: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> (!half_n && !almost_n)); // R8 R9

    AST_EMPTY_LEVELS: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> (half_n && !almost_n)); // R8 R9

    AST_WRITE_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && wr_en) |=> empty_n); // R2

endmodule

bind psf_fifo psf_fifo_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .sh_en    (sh_en),
    .so       (so),
    .empty_n  (empty_n),
    .full_n   (full_n),
    .half_n   (half_n),
    .almost_n (almost_n)
);

// File: tb/psf_fifo_bench.sv
module psf_fifo_bench;

    localparam int W     = 16;
    localparam int DEPTH = 1024;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         sh_en = 1'b0;
    logic         dir_msb = 1'b0;
    logic         so, empty_n, full_n, half_n, almost_n;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    string phase = "R1";

    // reference model state
    logic [W-1:0] q[$];
    int  pos = 0;
    bit  locked = 0;
    bit  msb_first = 0;
    bit  compare_on = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    psf_fifo #(.WORD_W(W), .DEPTH(DEPTH)) u_psf_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .sh_en(sh_en), .dir_msb(dir_msb), .so(so), .empty_n(empty_n),
        .full_n(full_n), .half_n(half_n), .almost_n(almost_n)
    );

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] actual=%b expected=%b t=%0t", tag, phase, act, exp, $time);
        end
    endtask

    // model update, from requirements R1..R10
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            q.delete();
            pos = 0;
            locked = 0;
            msb_first = 0;
        end else begin
            bit can_wr;
            bit can_sh;
            if (!locked) begin
                msb_first = dir_msb;
                locked = 1;
            end
            can_wr = wr_en && (q.size() < DEPTH);
            can_sh = sh_en && (q.size() > 0);
            if (can_sh) begin
                if (pos == W - 1) begin
                    pos = 0;
                    void'(q.pop_front());
                end else begin
                    pos++;
                end
            end
            if (can_wr) q.push_back(wr_data);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (compare_on && !rst) begin
            int n;
            logic exp_so;
            n = q.size();
            exp_so = 1'b0;
            if (n > 0) exp_so = msb_first ? q[0][W-1-pos] : q[0][pos];
            check("R2 R4 R5 so", so, exp_so);
            check("R6 empty_n", empty_n, n != 0);
            check("R7 full_n", full_n, n != DEPTH);
            check("R8 half_n", half_n, !(n > DEPTH / 2));
            check("R9 almost_n", almost_n, (n >= DEPTH / 8) && (n <= DEPTH - DEPTH / 8));
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(logic w, logic [W-1:0] d, logic s);
        @(negedge clk);
        wr_en = w;
        wr_data = d;
        sh_en = s;
    endtask

    task automatic next_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic do_reset(logic dir);
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        sh_en = 1'b0;
        dir_msb = dir;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        do_reset(1'b0);
        #1;
        check("R1 empty_n", empty_n, 1'b0);
        check("R1 almost_n", almost_n, 1'b0);
        check("R1 full_n", full_n, 1'b1);
        check("R1 half_n", half_n, 1'b1);
        check("R1 so", so, 1'b0);
        compare_on = 1;

        // R2 R4 R5: LSB-first, then shifting past empty
        phase = "R2 R4 R5 lsb";
        step(1, 16'h8001, 0);
        step(1, 16'h1234, 0);
        step(1, 16'hF0A5, 0);
        for (int i = 0; i < 3 * W + 6; i++) step(0, '0, 1);

        // R3 R6..R9: fill past capacity
        phase = "R3 R6 R7 R8 R9 fill";
        for (int i = 0; i < DEPTH + 6; i++) begin
            next_lfsr();
            step(1, lfsr, 0);
        end
        step(0, '0, 0);
        @(negedge clk);
        #1;
        check("R3 full after overfill", full_n, 1'b0);

        // R10: write and shift together while full
        phase = "R10 full";
        for (int i = 0; i < 2 * W + 3; i++) begin
            next_lfsr();
            step(1, lfsr, 1);
        end

        // R10: mixed random traffic
        phase = "R10 mixed";
        for (int i = 0; i < 6000; i++) begin
            next_lfsr();
            step(lfsr[3:0] == 4'h0 || lfsr[3:0] == 4'h7, lfsr, lfsr[8] | lfsr[11]);
        end

        // drain everything
        phase = "R4 R6 drain";
        for (int i = 0; i < DEPTH * W + 40; i++) step(0, '0, 1);
        step(0, '0, 0);
        @(negedge clk);
        #1;
        check("R6 drained", empty_n, 1'b0);

        // R5: MSB-first, direction changes later are ignored
        phase = "R5 msb";
        compare_on = 0;
        do_reset(1'b1);
        compare_on = 1;
        step(1, 16'h8000, 0);
        dir_msb = 1'b0;
        step(1, 16'h00FF, 0);
        step(1, 16'h5A3C, 0);
        dir_msb = 1'b1;
        step(1, 16'h0001, 0);
        dir_msb = 1'b0;
        for (int i = 0; i < 4 * W + 20; i++) begin
            next_lfsr();
            step(0, '0, lfsr[2] | lfsr[5]);
        end
        for (int i = 0; i < 4 * W; i++) step(0, '0, 1);

        // R3: writes during reset are dropped
        phase = "R3 reset write";
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b1;
        wr_data = 16'hBEEF;
        repeat (2) @(negedge clk);
        wr_en = 1'b0;
        rst = 1'b0;
        #1;
        check("R3 write in reset", empty_n, 1'b0);
        @(negedge clk);
        #1;
        check("R3 still empty", empty_n, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule